// File: doc/BRIEF.md
# Almost-Empty / Almost-Full Offset Programming Sequencer

This block holds the two threshold offsets that a deep first-in first-out buffer's flag logic compares against its fill level. The almost-empty threshold and the almost-full threshold are each stored as two byte-sized slots: a low byte and a narrower high part. The width of the high part follows from the buffer depth. Software or a controller reaches the four slots with no address lines. A single circular slot pointer picks the slot, and every qualifying access moves the pointer one step.

Programming uses the write clock. The shared load strobe and the primary write enable are both held low, and one slot is written on each edge. Readback uses the read clock. The load strobe and both read enables are held low, and one slot is copied to the data outputs on each edge. The write side and the read side each keep a mirror of the slot pointer. A toggle handshake carries every step across to the other mirror, so a run that stops part way continues from the next slot, whichever side makes the next access.

If a readback is requested while the write side is seen as loading, the write side wins. The read is dropped and its data is marked invalid. The assembled threshold values drive the flag logic without a gap.

Top module: `fl_offset_seq`

## Requirements
- R1: After synchronous reset (rst_n low at a clock edge), both low-byte slots hold 7 and both high parts hold 0, so empty_off and full_off read 7. rd_valid and rd_data are 0.
- R2: Successive write accesses (ld_n=0 and wen1_n=0 at a wr_clk edge) fill slots in this order: 0 = almost-empty low byte (wr_data[7:0]), 1 = almost-empty high part (wr_data[MSB_W-1:0]), 2 = almost-full low byte, 3 = almost-full high part. empty_off = {slot1, slot0} and full_off = {slot3, slot2}, with MSB_W = log2(DEPTH) - 8 (7 by default).
- R3: The access after slot 3 goes to slot 0 again.
- R4: A wr_clk edge with ld_n high or wen1_n high changes no slot.
- R5: Raising ld_n part way through a run keeps the pointer, so the next access goes to the slot after the last one written.
- R6: A read access (ld_n, ren1_n and ren2_n all low at an rd_clk edge, write side idle) puts the slot under the pointer on rd_data, zero-extended to DATA_W, and sets rd_valid to 1 after that edge. The pointer then advances.
- R7: Writes and reads step one shared pointer. Once the handshake has settled (SYNC_STAGES+1 cycles of the receiving clock), a read follows on from the last write, and a write follows on from the last read.
- R8: An rd_clk edge where any of ld_n, ren1_n or ren2_n is high leaves rd_data, rd_valid and the pointer unchanged.
- R9: A read request at an edge where the synchronised write-activity flag is set is blocked. rd_valid drops to 0, rd_data holds its value, and the pointer does not move for that request.
- R10: Reset puts the pointer back on slot 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-side clock |
| rd_clk | input | 1 | Read-side clock |
| rst_n | input | 1 | Synchronous active-low reset, sampled by both clocks |
| ld_n | input | 1 | Load strobe, active low; selects offset access |
| wen1_n | input | 1 | Primary write enable, active low |
| wr_data | input | DATA_W | Value written into the selected slot |
| ren1_n | input | 1 | First read enable, active low |
| ren2_n | input | 1 | Second read enable, active low |
| rd_data | output | DATA_W | Slot contents returned by readback |
| rd_valid | output | 1 | High when the last read request was served |
| empty_off | output | log2(DEPTH) | Assembled almost-empty threshold |
| full_off | output | log2(DEPTH) | Assembled almost-full threshold |

## Verification
The function most likely to collide is a slot write and a readback request that land on the same clock edge. The bench ties both clocks together. It holds the load strobe and the write enable low long enough for the write-activity flag to cross the synchroniser, then lowers both read enables while the writes continue. On that edge the bench expects four slots written in order, rd_valid low and rd_data unchanged. A later clean read must return the slot that follows the four writes, which shows the blocked request did not step the pointer.

// File: rtl/fl_offset_pkg.sv
`timescale 1ns/1ps
// Shared names for the offset programming sequencer.
// Assumes nothing beyond a two-bit slot pointer that wraps.
package fl_offset_pkg;
    typedef enum logic [1:0] {
        SLOT_E_LO = 2'd0,
        SLOT_E_HI = 2'd1,
        SLOT_F_LO = 2'd2,
        SLOT_F_HI = 2'd3
    } slot_e;

    localparam int          LO_W        = 8;
    localparam logic [7:0]  OFS_DEFAULT = 8'd7;
endpackage

// File: rtl/fl_flag_sync.sv
`timescale 1ns/1ps
// Multi-flop synchroniser for level and toggle signals from the other clock.
// Assumes each bit is independent and changes no more than once per
// destination-clock period.
module fl_flag_sync #(
    parameter int WIDTH  = 1,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] chain [STAGES];

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        if (i == 0) begin : g_first
            // First capture flop: samples the foreign signal.
            always_ff @(posedge clk) begin
                if (!rst_n) chain[i] <= '0;
                else        chain[i] <= d;
            end
        end else begin : g_next
            // Further flops: settle metastability.
            always_ff @(posedge clk) begin
                if (!rst_n) chain[i] <= '0;
                else        chain[i] <= chain[i-1];
            end
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/fl_offset_bank.sv
`timescale 1ns/1ps
// Write-clock side: the four offset slots, the write-side pointer mirror,
// and the toggle and busy signals handed to the read side.
// Assumes offset writes and reads are kept apart in time (see top header).
module fl_offset_bank
    import fl_offset_pkg::*;
#(
    parameter int DATA_W = 9,
    parameter int MSB_W  = 7
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  ld_n,
    input  logic                  wen1_n,
    input  logic [DATA_W-1:0]     wr_word,
    input  logic                  rd_tog_s,
    output logic                  wr_tog,
    output logic                  wr_busy,
    output logic [3:0][LO_W-1:0]  slot_q,
    output logic [LO_W+MSB_W-1:0] empty_off,
    output logic [LO_W+MSB_W-1:0] full_off
);
    logic             wr_acc;
    logic             rd_adv;
    logic             rd_tog_q;
    slot_e            wptr;
    logic [LO_W-1:0]  e_lo, f_lo;
    logic [MSB_W-1:0] e_hi, f_hi;
    logic [DATA_W-LO_W-1:0] unused_hi_bits;

    assign unused_hi_bits = wr_word[DATA_W-1:LO_W];
    assign wr_acc = !ld_n && !wen1_n;
    assign rd_adv = rd_tog_s ^ rd_tog_q;

    // Pointer mirror: local writes and read-side steps both advance it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wptr     <= SLOT_E_LO;
            rd_tog_q <= 1'b0;
        end else begin
            wptr     <= slot_e'(wptr + 2'(wr_acc) + 2'(rd_adv));
            rd_tog_q <= rd_tog_s;
        end
    end

    // Slot storage: one slot per qualifying write edge, defaults of 7.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            e_lo <= OFS_DEFAULT;
            f_lo <= OFS_DEFAULT;
            e_hi <= '0;
            f_hi <= '0;
        end else if (wr_acc) begin
            case (wptr)
                SLOT_E_LO: e_lo <= wr_word[LO_W-1:0];
                SLOT_E_HI: e_hi <= wr_word[MSB_W-1:0];
                SLOT_F_LO: f_lo <= wr_word[LO_W-1:0];
                default:   f_hi <= wr_word[MSB_W-1:0];
            endcase
        end
    end

    // Handshake out: toggle per step taken, busy level while loading.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_tog  <= 1'b0;
            wr_busy <= 1'b0;
        end else begin
            wr_tog  <= wr_tog ^ wr_acc;
            wr_busy <= wr_acc;
        end
    end

    assign slot_q[0] = e_lo;
    assign slot_q[1] = LO_W'(e_hi);
    assign slot_q[2] = f_lo;
    assign slot_q[3] = LO_W'(f_hi);
    assign empty_off = {e_hi, e_lo};
    assign full_off  = {f_hi, f_lo};

    AST_RESET_DEFAULT: assert property (@(posedge clk)
        !rst_n |=> (empty_off == (LO_W+MSB_W)'(7) && full_off == (LO_W+MSB_W)'(7) && wptr == SLOT_E_LO)); // R1
    AST_SLOT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_acc && !rd_adv) |=> (wptr == slot_e'($past(wptr) + 2'd1))); // R3
    AST_LO_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_acc && wptr == SLOT_E_LO) |=> (e_lo == $past(wr_word[LO_W-1:0]))); // R2
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_acc |=> ($stable(empty_off) && $stable(full_off))); // R4
endmodule

// File: rtl/fl_offset_readback.sv
`timescale 1ns/1ps
// Read-clock side: the read-side pointer mirror and the readback output
// register. Blocks any read while the write side is seen as loading.
// Assumes the slots are quasi-static whenever a read is served.
module fl_offset_readback
    import fl_offset_pkg::*;
#(
    parameter int DATA_W = 9
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 ld_n,
    input  logic                 ren1_n,
    input  logic                 ren2_n,
    input  logic                 wr_busy_s,
    input  logic                 wr_tog_s,
    input  logic [3:0][LO_W-1:0] slot_q,
    output logic                 rd_tog,
    output logic [DATA_W-1:0]    rd_data,
    output logic                 rd_valid
);
    logic  rd_req;
    logic  rd_acc;
    logic  wr_adv;
    logic  wr_tog_q;
    slot_e rptr;

    assign rd_req = !ld_n && !ren1_n && !ren2_n;
    assign rd_acc = rd_req && !wr_busy_s;
    assign wr_adv = wr_tog_s ^ wr_tog_q;

    // Pointer mirror: local reads and write-side steps both advance it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rptr     <= SLOT_E_LO;
            wr_tog_q <= 1'b0;
            rd_tog   <= 1'b0;
        end else begin
            rptr     <= slot_e'(rptr + 2'(rd_acc) + 2'(wr_adv));
            wr_tog_q <= wr_tog_s;
            rd_tog   <= rd_tog ^ rd_acc;
        end
    end

    // Output register: served reads load data; blocked reads clear valid.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data  <= '0;
            rd_valid <= 1'b0;
        end else if (rd_acc) begin
            rd_data  <= DATA_W'(slot_q[rptr]);
            rd_valid <= 1'b1;
        end else if (rd_req) begin
            rd_valid <= 1'b0;
        end
    end

    AST_READ_SERVED: assert property (@(posedge clk) disable iff (!rst_n)
        rd_acc |=> rd_valid); // R6
    AST_NO_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_req |=> ($stable(rd_data) && $stable(rd_valid))); // R8
    AST_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && wr_busy_s) |=> (!rd_valid && $stable(rd_data))); // R9
    AST_BLOCKED_NO_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && wr_busy_s) |=> $stable(rd_tog)); // R9
endmodule

// File: rtl/fl_offset_seq.sv
`timescale 1ns/1ps
// Threshold offset programming sequencer, top level.
// Four slots hold the almost-empty and almost-full offsets. They are reached
// through a circular pointer mirrored in both clock domains and kept in step
// by toggle handshakes. Assumes offset writes and reads are separated by at
// least SYNC_STAGES+2 cycles of the slower clock. An overlap that does reach
// the read side is resolved in favour of the write.
module fl_offset_seq
    import fl_offset_pkg::*;
#(
    parameter int DEPTH       = 32768,
    parameter int DATA_W      = 9,
    parameter int SYNC_STAGES = 2
) (
    input  logic                      wr_clk,
    input  logic                      rd_clk,
    input  logic                      rst_n,
    input  logic                      ld_n,
    input  logic                      wen1_n,
    input  logic [DATA_W-1:0]         wr_data,
    input  logic                      ren1_n,
    input  logic                      ren2_n,
    output logic [DATA_W-1:0]         rd_data,
    output logic                      rd_valid,
    output logic [$clog2(DEPTH)-1:0]  empty_off,
    output logic [$clog2(DEPTH)-1:0]  full_off
);
    localparam int ADDR_W = $clog2(DEPTH);
    localparam int MSB_W  = ADDR_W - LO_W;

    logic                 wr_tog, wr_busy, rd_tog;
    logic                 rd_tog_s;
    logic [1:0]           w2r_s;
    logic [3:0][LO_W-1:0] slot_q;

    fl_offset_bank #(
        .DATA_W (DATA_W),
        .MSB_W  (MSB_W)
    ) u_bank (
        .clk       (wr_clk),
        .rst_n     (rst_n),
        .ld_n      (ld_n),
        .wen1_n    (wen1_n),
        .wr_word   (wr_data),
        .rd_tog_s  (rd_tog_s),
        .wr_tog    (wr_tog),
        .wr_busy   (wr_busy),
        .slot_q    (slot_q),
        .empty_off (empty_off),
        .full_off  (full_off)
    );

    fl_flag_sync #(
        .WIDTH  (2),
        .STAGES (SYNC_STAGES)
    ) u_w2r (
        .clk   (rd_clk),
        .rst_n (rst_n),
        .d     ({wr_busy, wr_tog}),
        .q     (w2r_s)
    );

    fl_flag_sync #(
        .WIDTH  (1),
        .STAGES (SYNC_STAGES)
    ) u_r2w (
        .clk   (wr_clk),
        .rst_n (rst_n),
        .d     (rd_tog),
        .q     (rd_tog_s)
    );

    fl_offset_readback #(
        .DATA_W (DATA_W)
    ) u_rdbk (
        .clk       (rd_clk),
        .rst_n     (rst_n),
        .ld_n      (ld_n),
        .ren1_n    (ren1_n),
        .ren2_n    (ren2_n),
        .wr_busy_s (w2r_s[1]),
        .wr_tog_s  (w2r_s[0]),
        .slot_q    (slot_q),
        .rd_tog    (rd_tog),
        .rd_data   (rd_data),
        .rd_valid  (rd_valid)
    );
endmodule

// File: tb/tb_fl_offset_seq.sv
`timescale 1ns/1ps
// Directed bench: one task per scenario, both clocks tied to one 250 MHz clock.
module tb_fl_offset_seq;
    localparam int DEPTH   = 32768;
    localparam int DATA_W  = 9;
    localparam int OFS_W   = $clog2(DEPTH);
    localparam int HI_W    = OFS_W - 8;
    localparam int HI_MASK = (1 << HI_W) - 1;

    logic clk = 1'b0;
    logic rst_n, ld_n, wen1_n, ren1_n, ren2_n;
    logic [DATA_W-1:0] wr_data;
    logic [DATA_W-1:0] rd_data;
    logic rd_valid;
    logic [OFS_W-1:0] empty_off, full_off;

    int checks = 0;
    int failures = 0;
    int bm [4];
    int bptr;

    always #2 clk = ~clk;

    fl_offset_seq #(.DEPTH(DEPTH), .DATA_W(DATA_W), .SYNC_STAGES(2)) dut (
        .wr_clk(clk), .rd_clk(clk), .rst_n(rst_n), .ld_n(ld_n), .wen1_n(wen1_n),
        .wr_data(wr_data), .ren1_n(ren1_n), .ren2_n(ren2_n), .rd_data(rd_data),
        .rd_valid(rd_valid), .empty_off(empty_off), .full_off(full_off));

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic model_reset();
        bm[0] = 7; bm[1] = 0; bm[2] = 7; bm[3] = 0; bptr = 0;
    endtask

    function automatic int mask_for(int slot, int d);
        return (slot % 2 == 0) ? (d & 'hFF) : (d & HI_MASK);
    endfunction

    task automatic go_idle();
        ld_n = 1'b1; wen1_n = 1'b1; ren1_n = 1'b1; ren2_n = 1'b1;
    endtask

    task automatic settle();
        repeat (6) @(negedge clk);
    endtask

    task automatic wr1(input int d);
        ld_n = 1'b0; wen1_n = 1'b0; wr_data = DATA_W'(d);
        @(negedge clk);
        go_idle();
        bm[bptr] = mask_for(bptr, d);
        bptr = (bptr + 1) % 4;
    endtask

    task automatic rd1(input string tag);
        ld_n = 1'b0; ren1_n = 1'b0; ren2_n = 1'b0;
        @(negedge clk);
        go_idle();
        chk({tag, " rd_valid"}, int'(rd_valid), 1);
        chk({tag, " rd_data"}, int'(rd_data), bm[bptr]);
        bptr = (bptr + 1) % 4;
    endtask

    task automatic chk_offsets(input string tag);
        chk({tag, " empty_off"}, int'(empty_off), (bm[1] << 8) | bm[0]);
        chk({tag, " full_off"}, int'(full_off), (bm[3] << 8) | bm[2]);
    endtask

    task automatic do_reset();
        rst_n = 1'b0; go_idle(); wr_data = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        model_reset();
        @(negedge clk);
    endtask

    // R1, R10: defaults after reset and readback from slot 0 onward.
    task automatic t_reset();
        do_reset();
        chk("R1 empty_off default", int'(empty_off), 7);
        chk("R1 full_off default", int'(full_off), 7);
        chk("R1 rd_valid reset", int'(rd_valid), 0);
        chk("R1 rd_data reset", int'(rd_data), 0);
        for (int i = 0; i < 4; i++) rd1("R10 R6 default readback");
        settle();
    endtask

    // R2, R3: full programming run then wrap to slot 0.
    task automatic t_full_run();
        wr1('h1A5); wr1('h1FF); wr1('h03C); wr1('h155);
        chk_offsets("R2 four-slot run");
        wr1('h011);
        chk_offsets("R3 wrap to empty low byte");
        settle();
    endtask

    // R4, R8: non-qualifying strobes leave slots and readback untouched.
    task automatic t_ignored();
        int prev_d;
        int prev_v;
        prev_d = int'(rd_data); prev_v = int'(rd_valid);
        ld_n = 1'b1; wen1_n = 1'b0; wr_data = 'h0EE; @(negedge clk);
        ld_n = 1'b0; wen1_n = 1'b1; @(negedge clk);
        ren1_n = 1'b0; ren2_n = 1'b1; @(negedge clk);
        ren1_n = 1'b1; ren2_n = 1'b0; @(negedge clk);
        ld_n = 1'b1; ren1_n = 1'b0; ren2_n = 1'b0; @(negedge clk);
        go_idle();
        chk_offsets("R4 ignored write strobes");
        chk("R8 rd_data held", int'(rd_data), prev_d);
        chk("R8 rd_valid held", int'(rd_valid), prev_v);
        settle();
    endtask

    // R5: partial run, strobe raised, run resumes at the next slot.
    task automatic t_resume();
        wr1('h07A);
        settle();
        wr1('h0C3);
        chk_offsets("R5 resume after strobe release");
        settle();
    endtask

    // R6, R7: reads continue from writes and writes continue from reads.
    task automatic t_shared();
        rd1("R7 read after writes");
        rd1("R6 read next slot");
        settle();
        wr1('h1E4);
        chk_offsets("R7 write after reads");
        settle();
        rd1("R7 read after mixed");
        settle();
    endtask

    // R9: write and read on the same edge; write wins, read marked invalid.
    task automatic t_conflict();
        int prev_d;
        prev_d = int'(rd_data);
        ld_n = 1'b0; wen1_n = 1'b0;
        for (int i = 0; i < 4; i++) begin
            wr_data = DATA_W'('h120 + i * 'h11);
            if (i == 3) begin ren1_n = 1'b0; ren2_n = 1'b0; end
            @(negedge clk);
            bm[bptr] = mask_for(bptr, 'h120 + i * 'h11);
            bptr = (bptr + 1) % 4;
        end
        go_idle();
        chk("R9 blocked read invalid", int'(rd_valid), 0);
        chk("R9 blocked read data held", int'(rd_data), prev_d);
        chk_offsets("R9 writes kept priority");
        settle();
        rd1("R9 pointer not stepped by blocked read");
        settle();
    endtask

    // R10, R1: reset in mid-run restores defaults and slot 0.
    task automatic t_reset_mid();
        wr1('h0AB);
        do_reset();
        chk_offsets("R1 defaults after mid-run reset");
        rd1("R10 pointer back on slot 0");
        settle();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired (all R) actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        rst_n = 1'b0; go_idle(); wr_data = '0; model_reset();
        @(negedge clk);
        t_reset();
        t_full_run();
        t_ignored();
        t_resume();
        t_shared();
        t_conflict();
        t_reset_mid();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule